// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Result Pair Registers

This block carries out signed and unsigned integer multiplication and division on two operands. It works one bit per clock and writes its results into two registers of its own instead of into a general register file. After a multiply, the upper half of the double-width product is in the high register and the lower half is in the low register. After a divide, the quotient is in the low register and the remainder is in the high register.

A pipeline issues an operation by pulsing `start` with an operation code and two operands while the unit is idle. `busy` stays high until the result pair has been written. To move a result to a general register, the pipeline raises `rd_en` and selects one of the two registers with `rd_sel_hi`. The read data comes out combinationally. The read port has back-pressure: while an operation is in flight, any read request raises `rd_stall`, and the requester must hold its request until `rd_stall` drops. A read counts as complete only in a cycle where `rd_en` is high and `rd_stall` is low. The start port has no back-pressure. A `start` pulse that arrives while the unit is busy is dropped.

Top module: `mdu_top`

## Requirements
- R1: After reset, `busy` and `rd_stall` are low, and both result registers read as zero.
- R2: With op code 0 (signed multiply), the high register takes bits 63..32 and the low register takes bits 31..0 of the two's-complement 64-bit product of the operands.
- R3: With op code 1 (unsigned multiply), the result registers take the 64-bit unsigned product, split the same way as in R2.
- R4: With op code 3 (unsigned divide) and a non-zero divisor, the low register takes the quotient of `src_a / src_b` and the high register takes the remainder.
- R5: With op code 2 (signed divide) and a non-zero divisor, the quotient is truncated toward zero and the remainder has the sign of the dividend. The quotient of the most negative value divided by -1 is 0x80000000.
- R6: For either divide op with `src_b` zero, the low register becomes all ones and the high register becomes `src_a` unchanged.
- R7: `busy` rises on the cycle after an accepted `start` and stays high for exactly 33 cycles. The result registers are written on the clock edge at which `busy` falls, and they hold their values at all other times.
- R8: A `start` pulse while `busy` is high is ignored. It changes neither the result in flight nor the registers, and no further operation follows it.
- R9: `rd_stall` equals `rd_en` while `busy` is high and is low otherwise. `rd_data` is the high register when `rd_sel_hi` is 1 and the low register when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue an operation (taken only when idle) |
| op | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in flight |
| rd_en | input | 1 | Read request for a result register |
| rd_sel_hi | input | 1 | 1 selects the high register, 0 the low register |
| rd_data | output | 32 | Selected result register |
| rd_stall | output | 1 | Read must wait; unit busy |

## Verification
The bench targets the sign corners. These are a negative operand times a positive one, two most-negative values multiplied, the most-negative value divided by -1, and signed division with every sign combination. A design with a wrong sign fix-up would show up here as a quotient rounded toward minus infinity or a remainder that follows the divisor's sign. The full-range unsigned product 0xFFFFFFFF squared is aimed at a dropped carry in the shift-add step, which would corrupt the high half. Division by zero under both signednesses checks that the low register reads all ones and the high register reads the raw dividend, rather than a magnitude that has been negated. The bench also issues a start in the middle of an operation and measures the exact length of `busy`. A unit that latched the late command would either corrupt the pending result or produce an extra result that the scoreboard never expected.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'd0,
    OP_MUL_U = 2'd1,
    OP_DIV_S = 2'd2,
    OP_DIV_U = 2'd3
  } mdu_op_e;
endpackage

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           done_o,
  output logic [2*W-1:0] prod_o
);
  localparam int CW = $clog2(W + 1);

  logic           run_q;
  logic           done_q;
  logic [CW-1:0]  cnt_q;
  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] prod_q;
  logic [W:0]     sum;

  // partial sum of the upper half plus the multiplicand when the low bit is set
  always_comb begin
    sum = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      mcand_q <= '0;
      prod_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        run_q   <= 1'b1;
        cnt_q   <= CW'(W);
        mcand_q <= mcand_i;
        prod_q  <= {{W{1'b0}}, mplier_i};
      end else if (run_q) begin
        prod_q <= {sum, prod_q[W-1:1]};
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign prod_o = prod_q;

  assert_mul_fin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> done_q);
  assert_mul_cnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0));
endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);

  logic          run_q;
  logic          done_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  dvs_q;
  logic [W-1:0]  rem_q;
  logic [W-1:0]  quo_q;
  logic [W:0]    shifted;
  logic          fits;
  logic [W-1:0]  rem_nxt;

  // restoring step: bring in the next dividend bit, subtract when it fits
  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    fits    = (shifted >= {1'b0, dvs_q});
    rem_nxt = fits ? W'(shifted - {1'b0, dvs_q}) : shifted[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      dvs_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        run_q <= 1'b1;
        cnt_q <= CW'(W);
        dvs_q <= dvs_i;
        rem_q <= '0;
        quo_q <= dvd_i;
      end else if (run_q) begin
        rem_q <= rem_nxt;
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;

  assert_div_fin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> done_q);
  assert_div_rem_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  input  logic         busy,
  input  logic         rd_en,
  input  logic         rd_sel_hi,
  output logic [W-1:0] rd_data,
  output logic         rd_stall
);
  logic [W-1:0] hi_q;
  logic [W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (wr_en) begin
      hi_q <= hi_in;
      lo_q <= lo_in;
    end
  end

  assign rd_data  = rd_sel_hi ? hi_q : lo_q;
  assign rd_stall = rd_en && busy;

  assert_stall_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |-> busy);
  assert_regs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(hi_q) && $stable(lo_q)));
  assert_write_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);
endmodule

// File: rtl/mdu_top.sv
module mdu_top #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              busy,
  input  logic              rd_en,
  input  logic              rd_sel_hi,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_stall
);
  import mdu_pkg::*;
  localparam int W = DATA_W;

  mdu_op_e      op_e;
  logic         start_acc, is_div, is_signed, a_neg, b_neg;
  logic [W-1:0] mag_a, mag_b;
  logic         busy_q, div_q, neg_prod_q, neg_quo_q, neg_rem_q, dz_q;
  logic [W-1:0] a_raw_q;
  logic         mul_done, div_done, core_done;
  logic [2*W-1:0] prod, prod_fix;
  logic [W-1:0] quo, rem;
  logic [W-1:0] hi_res, lo_res;

  always_comb begin
    op_e      = mdu_op_e'(op);
    start_acc = start && !busy_q;
    is_div    = (op_e == OP_DIV_S) || (op_e == OP_DIV_U);
    is_signed = (op_e == OP_MUL_S) || (op_e == OP_DIV_S);
    a_neg     = is_signed && src_a[W-1];
    b_neg     = is_signed && src_b[W-1];
    mag_a     = a_neg ? (~src_a + 1'b1) : src_a;
    mag_b     = b_neg ? (~src_b + 1'b1) : src_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      div_q      <= 1'b0;
      neg_prod_q <= 1'b0;
      neg_quo_q  <= 1'b0;
      neg_rem_q  <= 1'b0;
      dz_q       <= 1'b0;
      a_raw_q    <= '0;
    end else if (core_done) begin
      busy_q <= 1'b0;
    end else if (start_acc) begin
      busy_q     <= 1'b1;
      div_q      <= is_div;
      neg_prod_q <= a_neg ^ b_neg;
      neg_quo_q  <= a_neg ^ b_neg;
      neg_rem_q  <= a_neg;
      dz_q       <= (src_b == '0);
      a_raw_q    <= src_a;
    end
  end

  mdu_mul_core #(.W(W)) i_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_acc && !is_div),
    .mcand_i  (mag_a),
    .mplier_i (mag_b),
    .done_o   (mul_done),
    .prod_o   (prod)
  );

  mdu_div_core #(.W(W)) i_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_acc && is_div),
    .dvd_i  (mag_a),
    .dvs_i  (mag_b),
    .done_o (div_done),
    .quo_o  (quo),
    .rem_o  (rem)
  );

  assign core_done = mul_done || div_done;

  // sign fix-up and divide-by-zero override
  always_comb begin
    prod_fix = neg_prod_q ? (~prod + 1'b1) : prod;
    if (div_q) begin
      if (dz_q) begin
        hi_res = a_raw_q;
        lo_res = '1;
      end else begin
        hi_res = neg_rem_q ? (~rem + 1'b1) : rem;
        lo_res = neg_quo_q ? (~quo + 1'b1) : quo;
      end
    end else begin
      hi_res = prod_fix[2*W-1:W];
      lo_res = prod_fix[W-1:0];
    end
  end

  mdu_hilo #(.W(W)) i_hilo (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (core_done),
    .hi_in     (hi_res),
    .lo_in     (lo_res),
    .busy      (busy_q),
    .rd_en     (rd_en),
    .rd_sel_hi (rd_sel_hi),
    .rd_data   (rd_data),
    .rd_stall  (rd_stall)
  );

  assign busy = busy_q;

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !core_done) |=> busy_q);
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> ($stable(a_raw_q) && $stable(div_q) && $stable(dz_q)));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mul_done, div_done}));
  assert_done_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |-> busy_q);
endmodule

// File: tb/test_mdu_top.sv
module test_mdu_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   op = 2'd0;
  logic [W-1:0] src_a = '0, src_b = '0;
  logic         busy, rd_stall;
  logic [W-1:0] rd_data;
  logic         rd_en_drv = 1'b0, rd_en_mon = 1'b0;
  logic         sel_drv = 1'b0, sel_mon = 1'b0;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  mdu_top #(.DATA_W(W)) i_mdu_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .src_a     (src_a),
    .src_b     (src_b),
    .busy      (busy),
    .rd_en     (rd_en_drv | rd_en_mon),
    .rd_sel_hi (sel_drv | sel_mon),
    .rd_data   (rd_data),
    .rd_stall  (rd_stall)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_model(input logic [1:0] o,
                                            input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa, sb, sq, sr;
    logic [63:0] ua, ub, uq, ur;
    sa = 64'(signed'(a));
    sb = 64'(signed'(b));
    ua = {32'd0, a};
    ub = {32'd0, b};
    case (o)
      2'd0: return sa * sb;
      2'd1: return ua * ub;
      2'd2: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        sq = sa / sb;
        sr = sa % sb;
        return {sr[31:0], sq[31:0]};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        uq = ua / ub;
        ur = ua % ub;
        return {ur[31:0], uq[31:0]};
      end
    endcase
  endfunction

  task automatic issue(input logic [1:0] o, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    while (busy) @(negedge clk);
    op = o; src_a = a; src_b = b; start = 1'b1;
    exp_q.push_back(ref_model(o, a, b));
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor: on each busy fall, read both registers and compare
  initial begin
    bit prev_busy = 1'b0;
    int blen = 0;
    logic [31:0] hi, lo;
    logic [63:0] e;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n && busy) blen++;
      else if (rst_n && prev_busy) begin
        chk(blen == W + 1, "R7", "busy length", 64'(blen), 64'(W + 1));
        blen = 0;
        rd_en_mon = 1'b1; sel_mon = 1'b1;
        #1 hi = rd_data;
        chk(rd_stall == 1'b0, "R9", "stall when idle", 64'(rd_stall), 64'd0);
        sel_mon = 1'b0;
        #1 lo = rd_data;
        rd_en_mon = 1'b0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected result", {hi, lo}, 64'd0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(hi == e[63:32], t, "high register", 64'(hi), 64'(e[63:32]));
          chk(lo == e[31:0], t, "low register", 64'(lo), 64'(e[31:0]));
        end
      end
      prev_busy = busy;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R7", "watchdog expired", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
    rd_en_drv = 1'b1; sel_drv = 1'b1;
    #1 chk(rd_data == '0, "R1", "high after reset", 64'(rd_data), 64'd0);
    chk(rd_stall == 1'b0, "R1", "stall after reset", 64'(rd_stall), 64'd0);
    sel_drv = 1'b0;
    #1 chk(rd_data == '0, "R1", "low after reset", 64'(rd_data), 64'd0);
    rd_en_drv = 1'b0;

    // R2 signed multiply
    issue(2'd0, 32'd7, 32'hFFFF_FFFD, "R2");
    issue(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    issue(2'd0, 32'h8000_0000, 32'h8000_0000, "R2");
    issue(2'd0, 32'h1234_5678, 32'h8765_4321, "R2");
    // R3 unsigned multiply
    issue(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    issue(2'd1, 32'd12345, 32'd6789, "R3");
    // R4 unsigned divide
    issue(2'd3, 32'd100, 32'd7, "R4");
    issue(2'd3, 32'hFFFF_FFFF, 32'd1, "R4");
    issue(2'd3, 32'd5, 32'd9, "R4");
    // R5 signed divide, all sign combinations
    issue(2'd2, 32'hFFFF_FFF9, 32'd2, "R5");
    issue(2'd2, 32'd7, 32'hFFFF_FFFE, "R5");
    issue(2'd2, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R5");
    issue(2'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R5");
    // R6 divide by zero
    issue(2'd2, 32'hFFFF_FFFB, 32'd0, "R6");
    issue(2'd3, 32'd42, 32'd0, "R6");

    // R9 stall while busy
    issue(2'd1, 32'd3, 32'd5, "R3");
    repeat (3) @(negedge clk);
    rd_en_drv = 1'b1;
    #1 chk(rd_stall == 1'b1, "R9", "stall while busy", 64'(rd_stall), 64'd1);
    rd_en_drv = 1'b0;
    #1 chk(rd_stall == 1'b0, "R9", "no stall without request", 64'(rd_stall), 64'd0);

    // R8 start while busy is ignored
    issue(2'd3, 32'd1000, 32'd3, "R8");
    repeat (5) @(negedge clk);
    op = 2'd1; src_a = 32'hDEAD_BEEF; src_b = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R8", "no extra operation", 64'(busy), 64'd0);
    chk(exp_q.size() == 0, "R8", "scoreboard drained", 64'(exp_q.size()), 64'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule